// File: doc/BRIEF.md
# Masked Interrupt Controller with Wake

This block gathers up to 32 single-cycle interrupt source pulses into a pending-flag register. Each pending bit is qualified by a per-source enable bit and by a one-bit master enable, and the result is a single level interrupt request to the CPU. A separate wake output rises for one cycle after any source pulse, whether or not that source is enabled. This lets a halted CPU resume even when it has not armed the request path.

Software sees the master enable, the 32-bit enable mask and the 32-bit pending-flag register as 16-bit halfwords, selected by a 3-bit halfword index. A wide write covers a low and high half pair in one cycle. The request is a combinational function of the stored registers. It therefore follows any write to the mask or to the master enable in the cycle right after the write edge, measured against the flags already pending. Pending flags are cleared by writing ones to them.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset all registers read zero, and both `irqReq` and `cpuWake` are low.
- R2: A pulse on source i sets pending bit i at the next edge, whatever the enable and master state. Sources 0 to 15 appear as bits 0 to 15 of index 4 (flag low). Sources 16 to 31 appear as bits 0 to 15 of index 5 (flag high). A flag bit never sets without a source pulse.
- R3: `cpuWake` is high in exactly the cycle after any source pulse, including masked sources.
- R4: `irqReq` is high only while the master enable is 1 and some bit is set in both the enable mask and the pending flags.
- R5: A write to the enable mask (index 2 = low half, index 3 = high half) changes `irqReq` in the cycle after the write edge, measured against the flags already pending.
- R6: Master enable is index 0 and stores only data bit 0; its other bits read as zero. Writing 1 while an enabled flag is pending raises `irqReq` in the next cycle.
- R7: Writing a 1 to a flag bit clears it, and writing a 0 leaves it unchanged. `irqReq` drops once no enabled flag remains.
- R8: When a source pulse and a clear of the same flag bit arrive in the same cycle, the bit ends up set.
- R9: A wide write (`wrWide`=1) ignores address bit 0. It puts `wrData[15:0]` in the low half and `wrData[31:16]` in the high half of the addressed register pair.
- R10: A narrow write changes only the addressed half, using `wrData[15:0]`. Indices 1, 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| srcPulse | input | 32 | One-cycle interrupt source pulses |
| wrEn | input | 1 | Register write strobe |
| wrWide | input | 1 | Write both halves of a register pair |
| wrAddr | input | 3 | Halfword index of the write |
| wrData | input | 32 | Write data |
| rdAddr | input | 3 | Halfword index of the read |
| rdData | output | 16 | Read data (combinational) |
| irqReq | output | 1 | Level interrupt request to the CPU |
| cpuWake | output | 1 | One-cycle wake for a halted CPU |

## Verification
Two functions can fall in the same cycle: a source pulse setting a flag bit, and a software write clearing that same bit. The bench drives both on one clock edge, a pulse on source 16 together with a write of 1 to bit 0 of the flag-high half. It then reads that half back and expects the bit to be set. The bench also combines a mask write with flags that are already pending, and judges whether the request moves in the very next cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int HALVES = 2;

  localparam logic [2:0] IDX_MASTER  = 3'd0;
  localparam logic [2:0] IDX_EN_LO   = 3'd2;
  localparam logic [2:0] IDX_EN_HI   = 3'd3;
  localparam logic [2:0] IDX_FLAG_LO = 3'd4;
  localparam logic [2:0] IDX_FLAG_HI = 3'd5;

  typedef struct packed {
    logic              masterWr;
    logic              masterVal;
    logic [HALVES-1:0] enWr;
    logic [HALVES-1:0] flagClr;
  } strobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                           wrEn,
  input  logic                           wrWide,
  input  logic [2:0]                     wrAddr,
  input  logic [HALVES*HALF_W-1:0]       wrData,
  output strobe_t                        strobe,
  output logic [HALVES-1:0][HALF_W-1:0]  halfData
);
  logic [2:0] baseIdx;

  always_comb begin
    baseIdx     = wrWide ? {wrAddr[2:1], 1'b0} : wrAddr;
    halfData[0] = wrData[HALF_W-1:0];
    halfData[1] = wrWide ? wrData[2*HALF_W-1:HALF_W] : wrData[HALF_W-1:0];
    strobe      = '0;
    if (wrEn) begin
      case (baseIdx)
        IDX_MASTER: begin
          strobe.masterWr  = 1'b1;
          strobe.masterVal = wrData[0];
        end
        IDX_EN_LO: begin
          strobe.enWr[0] = 1'b1;
          strobe.enWr[1] = wrWide;
        end
        IDX_EN_HI:   strobe.enWr[1] = 1'b1;
        IDX_FLAG_LO: begin
          strobe.flagClr[0] = 1'b1;
          strobe.flagClr[1] = wrWide;
        end
        IDX_FLAG_HI: strobe.flagClr[1] = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int SRC_W = HALVES * HALF_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SRC_W-1:0]              srcPulse,
  input  strobe_t                       strobe,
  input  logic [HALVES-1:0][HALF_W-1:0] halfData,
  input  logic [2:0]                    rdAddr,
  output logic [HALF_W-1:0]             rdData,
  output logic                          irqReq,
  output logic                          cpuWake,
  output logic [SRC_W-1:0]              flagVec,
  output logic [SRC_W-1:0]              enVec,
  output logic                          masterQ
);
  logic [HALVES-1:0][HALF_W-1:0] enQ;
  logic [HALVES-1:0][HALF_W-1:0] flagQ;
  logic                          wakeQ;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic [HALF_W-1:0] clrMask;
    assign clrMask = strobe.flagClr[h] ? halfData[h] : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        enQ[h]   <= '0;
        flagQ[h] <= '0;
      end else begin
        if (strobe.enWr[h]) enQ[h] <= halfData[h];
        // a source pulse wins over a clear of the same bit
        flagQ[h] <= (flagQ[h] & ~clrMask) | srcPulse[h*HALF_W +: HALF_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      masterQ <= 1'b0;
      wakeQ   <= 1'b0;
    end else begin
      if (strobe.masterWr) masterQ <= strobe.masterVal;
      wakeQ <= |srcPulse;
    end
  end

  assign enVec   = enQ;
  assign flagVec = flagQ;
  assign irqReq  = masterQ && ((enVec & flagVec) != '0);
  assign cpuWake = wakeQ;

  always_comb begin
    case (rdAddr)
      IDX_MASTER:  rdData = {{(HALF_W-1){1'b0}}, masterQ};
      IDX_EN_LO:   rdData = enQ[0];
      IDX_EN_HI:   rdData = enQ[1];
      IDX_FLAG_LO: rdData = flagQ[0];
      IDX_FLAG_HI: rdData = flagQ[1];
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irqc_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int SRC_W = HALVES * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  srcPulse,
  input  logic              wrEn,
  input  logic              wrWide,
  input  logic [2:0]        wrAddr,
  input  logic [SRC_W-1:0]  wrData,
  input  logic [2:0]        rdAddr,
  output logic [HALF_W-1:0] rdData,
  output logic              irqReq,
  output logic              cpuWake
);
  strobe_t                       strobe;
  logic [HALVES-1:0][HALF_W-1:0] halfData;
  logic [SRC_W-1:0]              flagVec;
  logic [SRC_W-1:0]              enVec;
  logic                          masterQ;

  irqc_ctrl #(.HALF_W(HALF_W)) u_ctrl (
    .wrEn(wrEn), .wrWide(wrWide), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .halfData(halfData)
  );

  irqc_datapath #(.HALF_W(HALF_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .srcPulse(srcPulse), .strobe(strobe),
    .halfData(halfData), .rdAddr(rdAddr), .rdData(rdData),
    .irqReq(irqReq), .cpuWake(cpuWake),
    .flagVec(flagVec), .enVec(enVec), .masterQ(masterQ)
  );
endmodule

// File: rtl/irq_mask_ctrl_chk.sv
module irq_mask_ctrl_chk #(
  parameter int SRC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SRC_W-1:0] srcPulse,
  input logic [SRC_W-1:0] flagVec,
  input logic [SRC_W-1:0] enVec,
  input logic             masterQ,
  input logic             irqReq,
  input logic             cpuWake
);
  // R3
  wake_after_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srcPulse != '0) |=> cpuWake);

  // R3
  no_idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srcPulse == '0) |=> !cpuWake);

  // R2
  src_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srcPulse != '0) |=> ((flagVec & $past(srcPulse)) == $past(srcPulse)));

  // R2
  no_spurious_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flagVec & ~$past(flagVec) & ~$past(srcPulse)) == '0));

  // R4
  req_needs_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> masterQ);

  // R4
  req_needs_enabled_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> ((enVec & flagVec) != '0));
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(.SRC_W(SRC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .srcPulse(srcPulse), .flagVec(flagVec),
  .enVec(enVec), .masterQ(masterQ), .irqReq(irqReq), .cpuWake(cpuWake)
);

// File: tb/irq_mask_ctrl_tb.sv
`timescale 1ns/1ps
module irq_mask_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] srcPulse = '0;
  logic        wrEn = 1'b0;
  logic        wrWide = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        irqReq;
  logic        cpuWake;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  irq_mask_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .srcPulse(srcPulse), .wrEn(wrEn),
    .wrWide(wrWide), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .irqReq(irqReq), .cpuWake(cpuWake)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one clock edge with the given stimulus; returns at the following falling edge
  task automatic step(input logic [31:0] pulse, input logic we, input logic wide,
                      input logic [2:0] addr, input logic [31:0] data);
    srcPulse = pulse; wrEn = we; wrWide = wide; wrAddr = addr; wrData = data;
    @(negedge clk);
    srcPulse = '0; wrEn = 1'b0; wrWide = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [15:0] val);
    rdAddr = idx; #0.5; val = rdData;
  endtask

  task automatic checkReg(input string req, input logic [2:0] idx, input logic [15:0] exp);
    logic [15:0] v;
    rd(idx, v);
    check(req, $sformatf("reg[%0d]", idx), {16'h0, v}, {16'h0, exp});
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) checkReg("R1", i[2:0], 16'h0);
    check("R1", "irqReq", {31'h0, irqReq}, 32'h0);
    check("R1", "cpuWake", {31'h0, cpuWake}, 32'h0);
    checkReg("R10", 3'd6, 16'h0);
  endtask

  task automatic t_masked_pulse;
    step(32'h0000_0008, 1'b0, 1'b0, 3'd0, 32'h0);
    checkReg("R2", 3'd4, 16'h0008);
    check("R3", "wake after masked pulse", {31'h0, cpuWake}, 32'h1);
    check("R4", "irq with nothing enabled", {31'h0, irqReq}, 32'h0);
    step(32'h0010_0000, 1'b0, 1'b0, 3'd0, 32'h0);
    checkReg("R2", 3'd5, 16'h0010);
    step(32'h0, 1'b0, 1'b0, 3'd0, 32'h0);
    check("R3", "wake idle", {31'h0, cpuWake}, 32'h0);
  endtask

  task automatic t_enable_and_master;
    step(32'h0, 1'b1, 1'b0, 3'd2, 32'h0000_0008);
    check("R4", "irq with master off", {31'h0, irqReq}, 32'h0);
    step(32'h0, 1'b1, 1'b0, 3'd0, 32'h0000_FFFF);
    check("R6", "irq after master on", {31'h0, irqReq}, 32'h1);
    checkReg("R6", 3'd0, 16'h0001);
    step(32'h0, 1'b1, 1'b0, 3'd2, 32'h0);
    check("R5", "irq after mask cleared", {31'h0, irqReq}, 32'h0);
    step(32'h0, 1'b1, 1'b0, 3'd3, 32'h0000_0010);
    check("R5", "irq after high mask set", {31'h0, irqReq}, 32'h1);
    checkReg("R10", 3'd2, 16'h0000);
    checkReg("R10", 3'd3, 16'h0010);
  endtask

  task automatic t_clear;
    step(32'h0, 1'b1, 1'b0, 3'd5, 32'h0);
    checkReg("R7", 3'd5, 16'h0010);
    step(32'h0, 1'b1, 1'b0, 3'd5, 32'h0000_0010);
    checkReg("R7", 3'd5, 16'h0000);
    check("R7", "irq after clear", {31'h0, irqReq}, 32'h0);
    checkReg("R7", 3'd4, 16'h0008);
  endtask

  task automatic t_collision;
    step(32'h0001_0000, 1'b1, 1'b0, 3'd5, 32'h0000_0001);
    checkReg("R8", 3'd5, 16'h0001);
    check("R8", "wake on collision", {31'h0, cpuWake}, 32'h1);
  endtask

  task automatic t_wide;
    step(32'h0, 1'b1, 1'b1, 3'd2, 32'hABCD_1234);
    checkReg("R9", 3'd2, 16'h1234);
    checkReg("R9", 3'd3, 16'hABCD);
    step(32'h0, 1'b1, 1'b1, 3'd5, 32'hFFFF_FFFF);
    checkReg("R9", 3'd4, 16'h0000);
    checkReg("R9", 3'd5, 16'h0000);
  endtask

  task automatic t_master_gate;
    step(32'h0000_0004, 1'b0, 1'b0, 3'd0, 32'h0);
    check("R4", "irq enabled pending", {31'h0, irqReq}, 32'h1);
    step(32'h0, 1'b1, 1'b0, 3'd0, 32'h0000_FFFE);
    check("R4", "irq master off", {31'h0, irqReq}, 32'h0);
    checkReg("R6", 3'd0, 16'h0000);
    step(32'h0, 1'b1, 1'b0, 3'd0, 32'h0000_0001);
    check("R6", "irq master back on", {31'h0, irqReq}, 32'h1);
    checkReg("R10", 3'd7, 16'h0);
    checkReg("R10", 3'd1, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_masked_pulse();
    t_enable_and_master();
    t_clear();
    t_collision();
    t_wide();
    t_master_gate();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule